// File: doc/BRIEF.md
# Pulse-Width Motor Command Serializer

This block turns an 11-bit throttle command per output lane into a 16-bit frame and plays it out on one wire per lane. Each of the 16 bits takes one fixed bit period. The value of a bit is carried by how long the line stays active at the start of that period: a long active time means one and a short one means zero. The frame holds the command, a one-shot telemetry request bit and a 4-bit checksum. The checksum is the XOR of the three nibbles of the 12-bit payload.

Software-side logic writes a command into a lane's pending slot. A single shared start strobe then launches every lane that holds a pending command, all in the same cycle, from one shared bit timer. The bit timer divides the clock by a programmable prescaler. It then counts prescaled ticks up to a programmable bit period. The one and zero active times are compare values in prescaled ticks. Each lane can invert its output. Each lane reports busy for the length of its frame and pulses done once at the end.

Top module: `motor_frame_tx`

## Requirements
- R1: A launched frame is {cmd[10:0], tlm, chk[3:0]}, where tlm is the lane's telemetry request flag and chk = p[11:8] ^ p[7:4] ^ p[3:0] with p = {cmd, tlm}.
- R2: The frame is sent most significant bit first. There are 16 bits, and each bit lasts exactly (presc+1)*bit_period clock cycles.
- R3: Within a bit, the raw line is active (1) for the first t1_high*(presc+1) cycles when the bit is one, or for the first t0_high*(presc+1) cycles when the bit is zero. It is inactive (0) for the rest of the bit.
- R4: A pulse on tlm_req sets the lane's telemetry flag. A launch consumes the flag, so the following frame carries tlm = 0 unless a new request arrives.
- R5: A write is ignored while enable is low or while the lane's chan_ok is low. A later start launches nothing on that lane.
- R6: When go is sampled high with enable high and no lane busy, every lane holding a pending command sets busy in the next cycle, all in the same cycle. Lanes with no pending command stay idle.
- R7: line = raw ^ invert. While a lane is not busy, its line equals its invert setting.
- R8: busy stays high from the cycle after the accepted start until the last bit period ends. In the first cycle with busy low again, done is high for exactly one cycle.
- R9: A write made while a frame is in progress is held in the pending slot and sent by the next start. A start strobe seen while any lane is busy is ignored.
- R10: After reset, busy and done are low, no command is pending, and line equals invert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Global enable for writes and starts |
| go | input | 1 | Shared start strobe |
| presc | input | PRESC_W | Prescaler; one tick every presc+1 clocks |
| bit_period | input | CNT_W | Ticks per bit |
| t1_high | input | CNT_W | Active ticks for a one |
| t0_high | input | CNT_W | Active ticks for a zero |
| chan_ok | input | NCH | Lane has a usable output |
| invert | input | NCH | Per-lane output inversion |
| wr_en | input | NCH | Per-lane command write strobe |
| cmd | input | NCH*11 | Packed 11-bit commands, lane i at [11*i +: 11] |
| tlm_req | input | NCH | Per-lane telemetry request pulse |
| line | output | NCH | Serial pulse outputs |
| busy | output | NCH | Lane is sending a frame |
| done | output | NCH | One-cycle end-of-frame pulse |

## Verification
The hardest case to reach is a write and a start strobe that arrive in the middle of a running frame. The write must land in the pending slot without disturbing the bits on the wire, and the start must not restart the shared timer. The stimulus injects both on a chosen lane partway through a frame. It then checks that the current frame plays out unchanged and that the next start sends the held command. Random frames vary the prescaler, the bit period, the lane mask, inversion and telemetry, so the timer's wrap points and the one-shot flag are hit under many combinations.

// File: rtl/mft_pkg.sv
// Shared widths and the frame packing function for the serializer.
package mft_pkg;
    localparam int CMD_W     = 11;
    localparam int PAYLOAD_W = CMD_W + 1;
    localparam int FRAME_W   = 16;
    localparam int BIDX_W    = $clog2(FRAME_W);

    // Packs command and telemetry flag, appending the folded nibble XOR.
    function automatic logic [FRAME_W-1:0] pack_frame(input logic [CMD_W-1:0] c,
                                                      input logic t);
        logic [PAYLOAD_W-1:0] p;
        p = {c, t};
        return {p, p[11:8] ^ p[7:4] ^ p[3:0]};
    endfunction
endpackage

// File: rtl/mft_bit_timer.sv
// Shared bit timer: prescaler, tick counter within a bit and bit index.
// Assumes presc, bit_period are stable for a whole frame and bit_period >= 1.
module mft_bit_timer #(
    parameter int PRESC_W = 8,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               run,
    input  logic [PRESC_W-1:0] presc,
    input  logic [CNT_W-1:0]   bit_period,
    output logic [CNT_W-1:0]   cnt,
    output logic               bit_end,
    output logic               frame_end
);
    import mft_pkg::*;

    logic [PRESC_W-1:0] pc;
    logic [BIDX_W-1:0]  idx;
    logic               tick;
    logic               wrap;

    assign tick      = run && (pc == presc);
    assign wrap      = (cnt == bit_period - CNT_W'(1));
    assign bit_end   = tick && wrap;
    assign frame_end = bit_end && (idx == BIDX_W'(FRAME_W - 1));

    // Advance prescaler, in-bit tick count and bit index; clear on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pc  <= '0;
            cnt <= '0;
            idx <= '0;
        end else if (run) begin
            if (tick) begin
                pc <= '0;
                if (wrap) begin
                    cnt <= '0;
                    idx <= idx + BIDX_W'(1);
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end else begin
                pc <= pc + PRESC_W'(1);
            end
        end
    end
endmodule

// File: rtl/mft_lane.sv
// One output lane: pending command slot, one-shot telemetry flag,
// frame shift register and pulse-width encoder driven by the shared timer.
// Assumes t1_high and t0_high do not exceed the bit period.
module mft_lane #(
    parameter int CNT_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_ok,
    input  logic [mft_pkg::CMD_W-1:0] cmd_in,
    input  logic                      tlm_set,
    input  logic                      start,
    input  logic                      bit_end,
    input  logic                      frame_end,
    input  logic [CNT_W-1:0]          cnt,
    input  logic [CNT_W-1:0]          t1_high,
    input  logic [CNT_W-1:0]          t0_high,
    input  logic                      invert,
    output logic                      line,
    output logic                      busy,
    output logic                      done
);
    import mft_pkg::*;

    logic               pend_v;
    logic [CMD_W-1:0]   pend_cmd;
    logic               tlm_flag;
    logic               run;
    logic [FRAME_W-1:0] shr;
    logic               launch;
    logic [CNT_W-1:0]   hi_ticks;

    assign launch = start && pend_v;

    // Pending slot: a write fills it, a launch empties it unless refilled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v   <= 1'b0;
            pend_cmd <= '0;
        end else if (wr_ok) begin
            pend_v   <= 1'b1;
            pend_cmd <= cmd_in;
        end else if (launch) begin
            pend_v   <= 1'b0;
        end
    end

    // Telemetry flag: set by request, consumed by the frame that carries it.
    always_ff @(posedge clk) begin
        if (!rst_n) tlm_flag <= 1'b0;
        else        tlm_flag <= tlm_set || (tlm_flag && !launch);
    end

    // Frame register: load on launch, shift per bit, release after bit 16.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            shr  <= '0;
            done <= 1'b0;
        end else begin
            done <= run && frame_end;
            if (launch) begin
                run <= 1'b1;
                shr <= pack_frame(pend_cmd, tlm_flag);
            end else if (run && frame_end) begin
                run <= 1'b0;
            end else if (run && bit_end) begin
                shr <= {shr[FRAME_W-2:0], 1'b0};
            end
        end
    end

    assign hi_ticks = shr[FRAME_W-1] ? t1_high : t0_high;
    assign line     = (run && (cnt < hi_ticks)) ^ invert;
    assign busy     = run;
endmodule

// File: rtl/motor_frame_tx.sv
// Top: NCH lanes sharing one bit timer and one start strobe.
// Assumes configuration inputs are held steady while any lane is busy.
module motor_frame_tx #(
    parameter int NCH     = 2,
    parameter int PRESC_W = 8,
    parameter int CNT_W   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enable,
    input  logic                          go,
    input  logic [PRESC_W-1:0]            presc,
    input  logic [CNT_W-1:0]              bit_period,
    input  logic [CNT_W-1:0]              t1_high,
    input  logic [CNT_W-1:0]              t0_high,
    input  logic [NCH-1:0]                chan_ok,
    input  logic [NCH-1:0]                invert,
    input  logic [NCH-1:0]                wr_en,
    input  logic [NCH*mft_pkg::CMD_W-1:0] cmd,
    input  logic [NCH-1:0]                tlm_req,
    output logic [NCH-1:0]                line,
    output logic [NCH-1:0]                busy,
    output logic [NCH-1:0]                done
);
    import mft_pkg::*;

    logic             any_busy;
    logic             start_ok;
    logic [CNT_W-1:0] cnt;
    logic             bit_end;
    logic             frame_end;

    assign any_busy = |busy;
    assign start_ok = go && enable && !any_busy;

    mft_bit_timer #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (start_ok),
        .run        (any_busy),
        .presc      (presc),
        .bit_period (bit_period),
        .cnt        (cnt),
        .bit_end    (bit_end),
        .frame_end  (frame_end)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        mft_lane #(.CNT_W(CNT_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_ok     (wr_en[i] && enable && chan_ok[i]),
            .cmd_in    (cmd[i*CMD_W +: CMD_W]),
            .tlm_set   (tlm_req[i]),
            .start     (start_ok),
            .bit_end   (bit_end),
            .frame_end (frame_end),
            .cnt       (cnt),
            .t1_high   (t1_high),
            .t0_high   (t0_high),
            .invert    (invert[i]),
            .line      (line[i]),
            .busy      (busy[i]),
            .done      (done[i])
        );
    end
endmodule

// File: rtl/mft_checker.sv
// Port-level properties of motor_frame_tx, bound to every instance.
module mft_checker #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           go,
    input logic           enable,
    input logic [NCH-1:0] invert,
    input logic [NCH-1:0] line,
    input logic [NCH-1:0] busy,
    input logic [NCH-1:0] done
);
    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R8: done only in the first idle cycle after a frame
        a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
            done[i] |-> (!busy[i] && $past(busy[i])));
        // R8: done lasts one cycle
        a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
            done[i] |=> !done[i]);
        // R7: idle line sits at the invert level
        a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
            !busy[i] |-> (line[i] == invert[i]));
        // R6: a frame begins only after an enabled start strobe
        a_r6_start_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy[i]) |-> $past(go && enable));
        // R9: no lane restarts while another frame is running
        a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy[i]) |-> ($past(busy) == '0));
    end
endmodule

bind motor_frame_tx mft_checker #(.NCH(NCH)) u_mft_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go),
    .enable (enable),
    .invert (invert),
    .line   (line),
    .busy   (busy),
    .done   (done)
);

// File: tb/tb_motor_frame_tx.sv
module tb_motor_frame_tx;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int CW  = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          go = 1'b0;
    logic [7:0]    presc = 8'd1;
    logic [7:0]    bit_period = 8'd8;
    logic [7:0]    t1_high = 8'd6;
    logic [7:0]    t0_high = 8'd3;
    logic [NCH-1:0] chan_ok = '1;
    logic [NCH-1:0] invert = '0;
    logic [NCH-1:0] wr_en = '0;
    logic [NCH*CW-1:0] cmd = '0;
    logic [NCH-1:0] tlm_req = '0;
    logic [NCH-1:0] line, busy, done;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // bench model of pending slots and telemetry flags
    logic [CW-1:0] m_cmd [NCH];
    logic          m_pv  [NCH];
    logic          m_tlm [NCH];

    // mid-frame injection control
    bit            inj_on = 0;
    int            inj_ch = 0;
    logic [CW-1:0] inj_cmd = '0;

    motor_frame_tx #(.NCH(NCH), .PRESC_W(8), .CNT_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .go(go), .presc(presc),
        .bit_period(bit_period), .t1_high(t1_high), .t0_high(t0_high),
        .chan_ok(chan_ok), .invert(invert), .wr_en(wr_en), .cmd(cmd),
        .tlm_req(tlm_req), .line(line), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] exp_frame(input logic [CW-1:0] c, input logic t);
        logic [11:0] p;
        logic [3:0]  k;
        p = {c, t};
        k = 4'(p >> 8) ^ 4'(p >> 4) ^ 4'(p);
        return {p, k};
    endfunction

    task automatic check(input string req, input bit ok, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cmd(input int ch, input logic [CW-1:0] c);
        @(negedge clk);
        wr_en[ch] = 1'b1;
        cmd[ch*CW +: CW] = c;
        @(negedge clk);
        wr_en = '0;
        if (enable && chan_ok[ch]) begin
            m_pv[ch]  = 1'b1;
            m_cmd[ch] = c;
        end
    endtask

    task automatic req_tlm(input int ch);
        @(negedge clk);
        tlm_req[ch] = 1'b1;
        @(negedge clk);
        tlm_req = '0;
        m_tlm[ch] = 1'b1;
    endtask

    // Launch with go and check every cycle of the frame on every lane.
    task automatic run_frame(input string tag);
        logic [15:0] fr [NCH];
        logic [NCH-1:0] armed;
        int w, len, busy_err;
        int mism [NCH];
        w = (int'(presc) + 1) * int'(bit_period);
        len = 16 * w;
        busy_err = 0;
        for (int c = 0; c < NCH; c++) begin
            armed[c] = m_pv[c];
            fr[c] = exp_frame(m_cmd[c], m_tlm[c]);
            mism[c] = 0;
            if (armed[c]) begin
                m_pv[c] = 1'b0;
                m_tlm[c] = 1'b0;
            end
        end
        @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        for (int s = 0; s < len; s++) begin
            for (int c = 0; c < NCH; c++) begin
                logic b, e;
                int pos;
                b = fr[c][15 - s / w];
                pos = (s % w) / (int'(presc) + 1);
                e = (armed[c] && (pos < int'(b ? t1_high : t0_high))) ^ invert[c];
                if (busy[c] !== armed[c]) busy_err++;
                if (line[c] !== e) mism[c]++;
            end
            if (inj_on && s == 40) begin
                wr_en[inj_ch] = 1'b1;
                cmd[inj_ch*CW +: CW] = inj_cmd;
                go = 1'b1;
            end
            if (inj_on && s == 41) begin
                wr_en = '0;
                go = 1'b0;
                m_pv[inj_ch] = 1'b1;
                m_cmd[inj_ch] = inj_cmd;
            end
            @(negedge clk);
        end
        for (int c = 0; c < NCH; c++)
            check({tag, " R1 R2 R3 line waveform"}, mism[c] == 0, mism[c], 0);
        check({tag, " R6 R8 busy window"}, busy_err == 0, busy_err, 0);
        check({tag, " R8 done pulse"}, done === armed && busy === '0,
              int'(done), int'(armed));
        check({tag, " R7 idle level"}, line === invert, int'(line), int'(invert));
        @(negedge clk);
        check({tag, " R8 done single cycle"}, done === '0, int'(done), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int c = 0; c < NCH; c++) begin
            m_cmd[c] = '0; m_pv[c] = 1'b0; m_tlm[c] = 1'b0;
        end
        invert = 2'b10;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset busy/done", busy === '0 && done === '0, int'(busy), 0);
        check("R10 reset line", line === invert, int'(line), int'(invert));
        rst_n = 1'b1;
        enable = 1'b1;
        @(negedge clk);
        // R6: start with nothing pending launches nothing
        @(negedge clk); go = 1'b1; @(negedge clk); go = 1'b0;
        repeat (3) @(negedge clk);
        check("R6 R10 nothing pending", busy === '0, int'(busy), 0);

        // R6: only lane 0 armed, all-zero command
        invert = '0;
        write_cmd(0, 11'h000);
        run_frame("d0");
        // R1 R4 R7: full-scale command with telemetry on both lanes, lane 1 inverted
        invert = 2'b10;
        write_cmd(0, 11'h7FF);
        write_cmd(1, 11'h7FF);
        req_tlm(0);
        req_tlm(1);
        run_frame("d1");
        // R4: telemetry flag gone in the next frame
        write_cmd(0, 11'h555);
        write_cmd(1, 11'h2AA);
        run_frame("d2");

        // R5: write ignored while disabled
        enable = 1'b0;
        write_cmd(0, 11'h123);
        enable = 1'b1;
        @(negedge clk); go = 1'b1; @(negedge clk); go = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 disabled write ignored", busy === '0, int'(busy), 0);
        // R5: write ignored on lane without valid output
        chan_ok = 2'b01;
        write_cmd(1, 11'h321);
        chan_ok = 2'b11;
        @(negedge clk); go = 1'b1; @(negedge clk); go = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 invalid lane write ignored", busy === '0, int'(busy), 0);

        // R9: write and start strobe during a running frame
        presc = 8'd0;
        write_cmd(0, 11'h0F0);
        inj_on = 1; inj_ch = 1; inj_cmd = 11'h3C5;
        run_frame("d3");
        inj_on = 0;
        check("R9 held command pending", m_pv[1] == 1'b1, 1, 1);
        run_frame("d4 R9 held command sent");

        // random frames
        for (int n = 0; n < 20; n++) begin
            presc = 8'($urandom_range(0, 2));
            bit_period = ($urandom_range(0, 1) == 0) ? 8'd8 : 8'd16;
            t1_high = 8'((int'(bit_period) * 3) / 4);
            t0_high = 8'((int'(bit_period) * 3) / 8);
            invert = 2'($urandom_range(0, 3));
            for (int c = 0; c < NCH; c++) begin
                if ($urandom_range(0, 3) != 0) write_cmd(c, 11'($urandom));
                if ($urandom_range(0, 1) == 1) req_tlm(c);
            end
            run_frame($sformatf("rnd%0d", n));
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule